// File: doc/BRIEF.md
# Flash Toggle-Bit Status Poller

After a host has launched an embedded program or erase inside a parallel NOR flash, this controller works out whether that operation has finished. A one-cycle `start` pulse begins an attempt. The controller then reads the flash data byte back to back and compares the toggle bit (bit 6) across each pair of reads. If the bit holds steady, the operation is over. If it toggles, the controller looks at the timeout flag (bit 5) in the newer byte.

When the timeout flag is set, one more pair of reads is taken. This is needed because the toggling can stop at the same moment the flag rises. A steady bit in that confirming pair counts as success. If the bit still toggles, the controller writes the reset command (0xF0) so the flash goes back to array reading, and then reports failure. When the flag is clear, the controller does one of two things, chosen per attempt: it keeps polling, bounded by a parameter, or it frees the bus with a pending result. A later `start` always begins with a fresh pair of reads.

Top module: `toggle_poller`

## Requirements
- R1: From reset, `busy`, `bus_rd`, `bus_wr` and `res_valid` are all 0. A `start` seen while idle raises `busy` and `bus_rd` in the next cycle.
- R2: Each poll pair is two consecutive cycles of `bus_rd`. The toggle bit of the second cycle is compared with that of the first cycle.
- R3: If bit 6 is equal in both reads of a pair, the result is DONE (code 2'b00).
- R4: If bit 6 differs, bit 5 is 0 and `persist` was 1 at start, another pair follows. It is judged independently.
- R5: If bit 6 differs and bit 5 is 1, one confirming pair follows whatever `persist` is. If that pair shows no toggle, the result is DONE.
- R6: If the confirming pair still toggles, exactly one `bus_wr` cycle with `bus_wdata` = 0xF0 is issued. In the next cycle the result is FAIL (code 2'b01).
- R7: If bit 6 differs, bit 5 is 0 and `persist` was 0, the result is PENDING (code 2'b10) after that single pair.
- R8: If MAX_POLLS pairs in a row all toggle with bit 5 at 0 (persist mode), the result is TIMEOUT (code 2'b11) after exactly 2*MAX_POLLS reads.
- R9: `res_valid` is high for exactly one cycle, in the same cycle that `busy` falls, with `res_code` valid.
- R10: A `start` pulse while `busy` is high has no effect on the sequence in progress or on its result.
- R11: Each new attempt ignores toggle values from earlier attempts. Its first pair is judged on its own two reads.
- R12: `bus_rd` and `bus_wr` are never high in the same cycle, and `bus_rd` is only high while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a status check |
| persist | input | 1 | Sampled at start: 1 keeps polling while bit 5 is clear, 0 gives up as pending |
| busy | output | 1 | High while an attempt is in progress |
| res_valid | output | 1 | One-cycle strobe marking the result |
| res_code | output | 2 | 00 done, 01 fail, 10 pending, 11 timeout |
| bus_rd | output | 1 | Read strobe; data is taken from bus_rdata in the same cycle |
| bus_wr | output | 1 | Write strobe for the reset command |
| bus_wdata | output | 8 | Write data, 0xF0 during bus_wr, otherwise 0 |
| bus_rdata | input | 8 | Flash data byte (bit 6 toggle, bit 5 timeout flag) |

## Verification
The assertions hold on every cycle for the bus rules and handshake rules. The read and write strobes never overlap, a read always sits inside busy, and a start seen while idle opens a read. Every write carries 0xF0 and is followed at once by a FAIL strobe. The result strobe lasts one cycle and coincides with busy falling. Which verdict comes out, how many reads led to it, that the confirming pair is taken, and that a new attempt forgets old toggle values all depend on the data the flash returns. Only the bench's scripted byte sequences can show these: steady, toggling-then-steady, flag-then-steady, flag-then-still-toggling, non-persistent release, the bounded timeout, and a start issued mid-run.

// File: rtl/tpoll_pkg.sv
package tpoll_pkg;

    localparam int DQ_W       = 8;
    localparam int TOGGLE_POS = 6;
    localparam int LIMIT_POS  = 5;
    localparam logic [DQ_W-1:0] RESET_CMD = 8'hF0;

    typedef enum logic [1:0] {
        RES_DONE = 2'b00,
        RES_FAIL = 2'b01,
        RES_PEND = 2'b10,
        RES_TMO  = 2'b11
    } res_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_A,
        ST_RD_B,
        ST_RST_WR
    } st_e;

    typedef struct packed {
        logic toggled;
        logic limit_hit;
    } verdict_t;

    function automatic verdict_t judge(input logic first6, input logic [DQ_W-1:0] rd);
        verdict_t v;
        v.toggled   = first6 ^ rd[TOGGLE_POS];
        v.limit_hit = rd[LIMIT_POS];
        return v;
    endfunction

endpackage

// File: rtl/tpoll_sample.sv
module tpoll_sample
    import tpoll_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [DQ_W-1:0] rdata,
    output verdict_t        verdict
);
    logic first6;

    always_ff @(posedge clk) begin
        if (rst)       first6 <= 1'b0;
        else if (load) first6 <= rdata[TOGGLE_POS];
    end

    always_comb verdict = judge(first6, rdata);
endmodule

// File: rtl/tpoll_budget.sv
module tpoll_budget #(
    parameter int MAX_POLLS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic step,
    output logic last
);
    localparam int CW = (MAX_POLLS < 2) ? 1 : $clog2(MAX_POLLS);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) cnt <= '0;
        else if (step)    cnt <= cnt + 1'b1;
    end

    assign last = (cnt == CW'(MAX_POLLS - 1));
endmodule

// File: rtl/tpoll_fsm.sv
module tpoll_fsm
    import tpoll_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     persist,
    input  verdict_t verdict,
    input  logic     last,
    output logic     busy,
    output logic     rd_en,
    output logic     wr_en,
    output logic     load_first,
    output logic     clr_budget,
    output logic     step_budget,
    output logic     res_valid,
    output res_e     res_code
);
    st_e  state;
    logic recheck;
    logic persist_q;

    always_comb begin
        busy        = (state != ST_IDLE);
        rd_en       = (state == ST_RD_A) || (state == ST_RD_B);
        wr_en       = (state == ST_RST_WR);
        load_first  = (state == ST_RD_A);
        clr_budget  = (state == ST_IDLE) && start;
        step_budget = (state == ST_RD_B) && verdict.toggled && !recheck &&
                      !verdict.limit_hit && persist_q && !last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            recheck   <= 1'b0;
            persist_q <= 1'b0;
            res_valid <= 1'b0;
            res_code  <= RES_DONE;
        end else begin
            res_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state     <= ST_RD_A;
                        recheck   <= 1'b0;
                        persist_q <= persist;
                    end
                end
                ST_RD_A: state <= ST_RD_B;
                ST_RD_B: begin
                    if (!verdict.toggled) begin
                        state     <= ST_IDLE;
                        res_valid <= 1'b1;
                        res_code  <= RES_DONE;
                    end else if (recheck) begin
                        state <= ST_RST_WR;
                    end else if (verdict.limit_hit) begin
                        recheck <= 1'b1;
                        state   <= ST_RD_A;
                    end else if (!persist_q) begin
                        state     <= ST_IDLE;
                        res_valid <= 1'b1;
                        res_code  <= RES_PEND;
                    end else if (last) begin
                        state     <= ST_IDLE;
                        res_valid <= 1'b1;
                        res_code  <= RES_TMO;
                    end else begin
                        state <= ST_RD_A;
                    end
                end
                ST_RST_WR: begin
                    state     <= ST_IDLE;
                    res_valid <= 1'b1;
                    res_code  <= RES_FAIL;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/toggle_poller.sv
module toggle_poller
    import tpoll_pkg::*;
#(
    parameter int MAX_POLLS = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       persist,
    output logic       busy,
    output logic       res_valid,
    output logic [1:0] res_code,
    output logic       bus_rd,
    output logic       bus_wr,
    output logic [7:0] bus_wdata,
    input  logic [7:0] bus_rdata
);
    verdict_t verdict;
    logic     load_first, clr_budget, step_budget, last;
    res_e     code_e;

    tpoll_sample u_sample (
        .clk     (clk),
        .rst     (rst),
        .load    (load_first),
        .rdata   (bus_rdata),
        .verdict (verdict)
    );

    tpoll_budget #(.MAX_POLLS(MAX_POLLS)) u_budget (
        .clk   (clk),
        .rst   (rst),
        .clear (clr_budget),
        .step  (step_budget),
        .last  (last)
    );

    tpoll_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .persist     (persist),
        .verdict     (verdict),
        .last        (last),
        .busy        (busy),
        .rd_en       (bus_rd),
        .wr_en       (bus_wr),
        .load_first  (load_first),
        .clr_budget  (clr_budget),
        .step_budget (step_budget),
        .res_valid   (res_valid),
        .res_code    (code_e)
    );

    assign res_code  = code_e;
    assign bus_wdata = bus_wr ? RESET_CMD : 8'h00;
endmodule

// File: rtl/tpoll_chk.sv
module tpoll_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       busy,
    input logic       res_valid,
    input logic [1:0] res_code,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic [7:0] bus_wdata
);
    assert_rd_wr_excl_R12: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr));

    assert_rd_in_busy_R12: assert property (@(posedge clk) disable iff (rst)
        bus_rd |-> busy);

    assert_start_opens_R1: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && bus_rd));

    assert_pair_len_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_rd) |=> bus_rd);

    assert_cmd_data_R6: assert property (@(posedge clk) disable iff (rst)
        bus_wr |-> (bus_wdata == 8'hF0));

    assert_wr_then_fail_R6: assert property (@(posedge clk) disable iff (rst)
        bus_wr |=> (res_valid && res_code == 2'b01));

    assert_valid_on_fall_R9: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (!busy && $past(busy)));

    assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);
endmodule

bind toggle_poller tpoll_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .res_valid (res_valid),
    .res_code  (res_code),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata)
);

// File: tb/tb_toggle_poller.sv
module tb_toggle_poller;
    localparam int MAXP = 8;
    localparam int SEQ_N = 24;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       persist = 1'b0;
    logic       busy, res_valid, bus_rd, bus_wr;
    logic [1:0] res_code;
    logic [7:0] bus_wdata, bus_rdata;

    always #5 clk = ~clk;

    toggle_poller #(.MAX_POLLS(MAXP)) dut (
        .clk(clk), .rst(rst), .start(start), .persist(persist),
        .busy(busy), .res_valid(res_valid), .res_code(res_code),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    typedef struct {
        logic [1:0] code;
        int         reads;
        int         writes;
        string      tag;
    } exp_t;

    exp_t       sb[$];
    logic [7:0] seq [SEQ_N];
    int         rd_cnt = 0;
    int         wr_cnt = 0;
    logic [7:0] last_wdata = 8'h00;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done_flag = 0;

    // flash model: the byte returned depends on how many reads this attempt has made
    assign bus_rdata = seq[(rd_cnt < SEQ_N) ? rd_cnt : SEQ_N-1];

    always_ff @(posedge clk) begin
        if (start && !busy) begin
            rd_cnt <= 0;
            wr_cnt <= 0;
        end else begin
            if (bus_rd) rd_cnt <= rd_cnt + 1;
            if (bus_wr) begin
                wr_cnt     <= wr_cnt + 1;
                last_wdata <= bus_wdata;
            end
        end
    end

    function automatic logic [7:0] fb(input bit t6, input bit t5);
        return {1'b0, t6, t5, 5'b0};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // monitor: pops the scoreboard on each result strobe
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            exp_t e;
            if (sb.size() == 0) begin
                check(0, "R9 unexpected result", 1, 0);
            end else begin
                e = sb.pop_front();
                check(res_code == e.code, {e.tag, " code"}, res_code, e.code);
                check(rd_cnt == e.reads, {e.tag, " reads"}, rd_cnt, e.reads);
                check(wr_cnt == e.writes, {e.tag, " writes"}, wr_cnt, e.writes);
                check(!busy, "R9 busy low with result", busy, 0);
                if (e.writes > 0)
                    check(last_wdata == 8'hF0, "R6 reset command data", last_wdata, 8'hF0);
            end
        end
    end

    task automatic fill(input logic [7:0] b);
        for (int i = 0; i < SEQ_N; i++) seq[i] = b;
    endtask

    task automatic run(input bit pers, input logic [1:0] code, input int reads,
                       input int writes, input string tag, input int extra_start_at);
        exp_t e;
        int   cyc;
        e.code = code; e.reads = reads; e.writes = writes; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        persist = pers;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        persist = ~pers;
        check(busy && bus_rd, "R1 busy and read after start", busy, 1);
        cyc = 1;
        while (!res_valid) begin
            if (cyc == extra_start_at) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        @(negedge clk);
        check(!res_valid, "R9 result one cycle", res_valid, 0);
    endtask

    task automatic finish_up;
        if (!done_flag) begin
            done_flag = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        finish_up();
    end

    initial begin
        fill(fb(1, 0));
        repeat (3) @(negedge clk);
        check(!busy && !bus_rd && !bus_wr && !res_valid, "R1 reset state", busy, 0);
        rst = 1'b0;

        // R3: steady toggle bit
        fill(fb(1, 0));
        run(1, 2'b00, 2, 0, "R3", -1);

        // R4: toggling, flag clear, then steady (second pair judged alone)
        fill(fb(1, 0)); seq[0] = fb(0, 0);
        run(1, 2'b00, 4, 0, "R4", -1);

        // R5: flag rises with toggle, confirming pair steady
        fill(fb(1, 1)); seq[0] = fb(0, 0);
        run(1, 2'b00, 4, 0, "R5", -1);

        // R5: confirming pair taken even without persist
        run(0, 2'b00, 4, 0, "R5 nopersist", -1);

        // R6: confirming pair still toggles -> reset write, FAIL
        fill(fb(1, 1)); seq[0] = fb(0, 0); seq[2] = fb(0, 1);
        run(1, 2'b01, 4, 1, "R6", -1);

        // R7: non-persistent release as pending
        fill(fb(1, 0)); seq[0] = fb(0, 0);
        run(0, 2'b10, 2, 0, "R7", -1);

        // R11: fresh attempt, earlier toggle value not reused
        fill(fb(1, 0));
        run(1, 2'b00, 2, 0, "R11", -1);
        fill(fb(0, 0));
        run(1, 2'b00, 2, 0, "R11 low", -1);

        // R8 and R10: endless toggling, extra start mid-run ignored
        for (int i = 0; i < SEQ_N; i++) seq[i] = fb(i % 2 == 1, 0);
        run(1, 2'b11, 2*MAXP, 0, "R8 R10", 5);

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R9 all results seen", sb.size(), 0);
        check(!bus_rd && !bus_wr && !busy, "R12 quiet when idle", bus_rd, 0);
        finish_up();
    end
endmodule